// File: doc/BRIEF.md
# Power Sequence Command Engine

The engine walks a read-only table of power-configuration entries, starting at index zero each time it is started. Each entry carries a byte-register offset, three chip-identity masks (cut, fab and interface), an address-space selector, an opcode, a bit mask and a data value. An entry runs only when every one of its identity masks overlaps the matching identity input. Entries that fail this test, and entries whose opcode does nothing, are stepped over.

The entry types are a masked read-modify-write of one byte, a poll that rereads a byte until its masked bits match, a timed wait counted in microseconds or milliseconds, and a terminator. Register traffic uses a byte-wide request/acknowledge bus with a one-bit space select. One poll-attempt budget covers the whole run and is cleared only when the run starts. A run ends with a one-cycle done pulse that carries a pass or fail flag.

All timing comes from a microsecond tick. The tick is derived from the clock frequency, which is given as a parameter.

Top module: `pwr_seq_engine`

## Requirements
- R1: An entry runs only if (fab mask & fab_ver), (cut mask & cut_ver) and (interface mask & intf_ver) are all nonzero. Any other entry makes no bus access, and the index advances.
- R2: A write entry (opcode 1) reads the byte at its offset, then writes (read & ~mask) | (value & mask) back to the same offset.
- R3: bus_sel is 1 (secondary local space) when the entry's space field equals LOCAL_SPACE (default 1). It is 0 (system register space) for every other code.
- R4: A poll entry (opcode 2) rereads its offset until (read & mask) == (value & mask), then advances. Successive poll reads are at least POLL_GAP_US microseconds (POLL_GAP_US*CLK_MHZ cycles) apart.
- R5: Every poll read increments one attempt counter, including the read that matches. A poll read made while the counter already exceeds POLL_LIMIT ends the run with pass=0. With limit L, the run fails on read L+2 counted across all poll entries.
- R6: A delay entry (opcode 3) waits offset microseconds when its value field is 0, and offset milliseconds for any other value.
- R7: An end entry (opcode 4) ends the run with done=1 and pass=1. Later entries are not executed.
- R8: Opcode 0 and opcodes 5 to 15 make no bus access, and the engine moves on to the next entry.
- R9: A start pulse while idle clears the index (tbl_addr=0 on the next cycle) and the poll counter. A start pulse while busy has no effect.
- R10: After reset, busy, done and bus_req are 0. busy goes high the cycle after an accepted start and stays high until done. done is a single-cycle pulse with busy low, and pass is valid with it.
- R11: bus_addr, bus_we, bus_sel and bus_wdata hold steady while bus_req is high and bus_ack is low. bus_rdata is used only in the cycle bus_ack is high.
- R12: The table returns an entry one cycle after tbl_addr. The entry bits, MSB first, are: offset[55:40], cut[39:32], fab[31:28], interface[27:24], space[23:20], opcode[19:16], mask[15:8], value[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| cut_ver | input | 8 | Cut identity, one-hot style |
| fab_ver | input | 4 | Fab identity |
| intf_ver | input | 4 | Host interface identity |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run result, valid with done |
| tbl_addr | output | IDX_W | Table index |
| tbl_data | input | 56 | Table entry, one cycle after tbl_addr |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_sel | output | 1 | 1 = local space, 0 = system space |
| bus_addr | output | 16 | Register byte offset |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access acknowledge |
| bus_rdata | input | 8 | Read data, valid with bus_ack |

## Verification
The checker relies on three things about the environment:
- bus_ack is raised only while bus_req is high, and for one cycle per access.
- start is a single-cycle pulse.
- The table returns its entry one cycle after the address.

The bench's responder acknowledges after zero to two wait cycles, drops bus_ack right after each acknowledge, and drives junk on bus_rdata when not acknowledging. Its table model is a registered array lookup. The bench raises start for one cycle only, and it does so once while the engine is busy to show that such a pulse is ignored.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
   localparam int OFS_W = 16;
   localparam int CUT_W = 8;
   localparam int FAB_W = 4;
   localparam int IFC_W = 4;
   localparam int SPC_W = 4;
   localparam int OPC_W = 4;
   localparam int DAT_W = 8;
   localparam int ENTRY_W = OFS_W + CUT_W + FAB_W + IFC_W + SPC_W + OPC_W + 2 * DAT_W;

   typedef enum logic [OPC_W-1:0] {
      OP_READ  = 4'd0,
      OP_WRITE = 4'd1,
      OP_POLL  = 4'd2,
      OP_DELAY = 4'd3,
      OP_END   = 4'd4
   } opc_e;

   typedef struct packed {
      logic [OFS_W-1:0] ofs;
      logic [CUT_W-1:0] cut_m;
      logic [FAB_W-1:0] fab_m;
      logic [IFC_W-1:0] ifc_m;
      logic [SPC_W-1:0] space;
      logic [OPC_W-1:0] opc;
      logic [DAT_W-1:0] bmask;
      logic [DAT_W-1:0] bval;
   } entry_t;
endpackage

// File: rtl/pwrseq_filter.sv
module pwrseq_filter import pwrseq_pkg::*; (
   input  logic [CUT_W-1:0] cut_m,
   input  logic [FAB_W-1:0] fab_m,
   input  logic [IFC_W-1:0] ifc_m,
   input  logic [CUT_W-1:0] cut_ver,
   input  logic [FAB_W-1:0] fab_ver,
   input  logic [IFC_W-1:0] intf_ver,
   output logic             hit
);
   logic cut_ok, fab_ok, ifc_ok;

   assign cut_ok = |(cut_m & cut_ver);
   assign fab_ok = |(fab_m & fab_ver);
   assign ifc_ok = |(ifc_m & intf_ver);
   assign hit    = cut_ok & fab_ok & ifc_ok;
endmodule

// File: rtl/pwrseq_bitops.sv
module pwrseq_bitops #(
   parameter int W = 8
) (
   input  logic [W-1:0] rdata,
   input  logic [W-1:0] bmask,
   input  logic [W-1:0] bval,
   output logic [W-1:0] merged,
   output logic         match
);
   logic [W-1:0] want;

   assign want   = bval & bmask;
   assign merged = (rdata & ~bmask) | want;
   assign match  = ((rdata & bmask) == want);
endmodule

// File: rtl/pwrseq_delay.sv
module pwrseq_delay #(
   parameter int CLK_MHZ = 200,
   parameter int CNT_W   = 26
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] units,
   output logic             fin
);
   logic             run_q;
   logic [CNT_W-1:0] rem_q;
   logic             us_wrap;

   generate
      if (CLK_MHZ == 1) begin : g_direct
         assign us_wrap = 1'b1;
      end else begin : g_prescale
         localparam int PRE_W = $clog2(CLK_MHZ);
         logic [PRE_W-1:0] pre_q;
         assign us_wrap = (pre_q == PRE_W'(CLK_MHZ - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  pre_q <= '0;
            else if (start || !run_q)    pre_q <= '0;
            else if (us_wrap)            pre_q <= '0;
            else                         pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         rem_q <= '0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (start) begin
            run_q <= 1'b1;
            rem_q <= units;
         end else if (run_q) begin
            if (rem_q == '0) begin
               run_q <= 1'b0;
               fin   <= 1'b1;
            end else if (us_wrap) begin
               rem_q <= rem_q - 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pwr_seq_engine.sv
module pwr_seq_engine import pwrseq_pkg::*; #(
   parameter int IDX_W       = 8,
   parameter int CLK_MHZ     = 200,
   parameter int POLL_LIMIT  = 5000,
   parameter int POLL_GAP_US = 10,
   parameter int LOCAL_SPACE = 1,
   parameter int US_CODE     = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [CUT_W-1:0]   cut_ver,
   input  logic [FAB_W-1:0]   fab_ver,
   input  logic [IFC_W-1:0]   intf_ver,
   output logic               busy,
   output logic               done,
   output logic               pass,
   output logic [IDX_W-1:0]   tbl_addr,
   input  logic [ENTRY_W-1:0] tbl_data,
   output logic               bus_req,
   output logic               bus_we,
   output logic               bus_sel,
   output logic [OFS_W-1:0]   bus_addr,
   output logic [DAT_W-1:0]   bus_wdata,
   input  logic               bus_ack,
   input  logic [DAT_W-1:0]   bus_rdata
);
   localparam int CNT_W  = OFS_W + 10;
   localparam int PCNT_W = $clog2(POLL_LIMIT + 3) + 1;

   generate
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("CLK_MHZ must be at least 1");
      end
      if (POLL_LIMIT < 1) begin : g_bad_limit
         $error("POLL_LIMIT must be at least 1");
      end
      if (LOCAL_SPACE >= (1 << SPC_W)) begin : g_bad_space
         $error("LOCAL_SPACE does not fit the space field");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("IDX_W must be at least 1");
      end
   endgenerate

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_DECODE, S_RD, S_WR, S_GAP, S_DLY, S_NEXT
   } state_t;

   state_t             st_q;
   logic [IDX_W-1:0]   idx_q;
   logic [PCNT_W-1:0]  pcnt_q;
   logic [OFS_W-1:0]   ofs_q;
   logic [SPC_W-1:0]   spc_q;
   logic [OPC_W-1:0]   opc_q;
   logic [DAT_W-1:0]   msk_q;
   logic [DAT_W-1:0]   val_q;
   logic [DAT_W-1:0]   wdat_q;
   logic               tmr_go_q;
   logic [CNT_W-1:0]   tmr_len_q;
   logic               tmr_fin;
   logic               ent_hit;
   logic [DAT_W-1:0]   merged;
   logic               poll_match;
   entry_t             cur;

   assign cur = entry_t'(tbl_data);

   pwrseq_filter u_filter (
      .cut_m    (cur.cut_m),
      .fab_m    (cur.fab_m),
      .ifc_m    (cur.ifc_m),
      .cut_ver  (cut_ver),
      .fab_ver  (fab_ver),
      .intf_ver (intf_ver),
      .hit      (ent_hit)
   );

   pwrseq_bitops #(.W(DAT_W)) u_bitops (
      .rdata  (bus_rdata),
      .bmask  (msk_q),
      .bval   (val_q),
      .merged (merged),
      .match  (poll_match)
   );

   pwrseq_delay #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .start (tmr_go_q),
      .units (tmr_len_q),
      .fin   (tmr_fin)
   );

   assign busy      = (st_q != S_IDLE);
   assign tbl_addr  = idx_q;
   assign bus_req   = (st_q == S_RD) || (st_q == S_WR);
   assign bus_we    = (st_q == S_WR);
   assign bus_sel   = (spc_q == SPC_W'(LOCAL_SPACE));
   assign bus_addr  = ofs_q;
   assign bus_wdata = wdat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= S_IDLE;
         idx_q     <= '0;
         pcnt_q    <= '0;
         ofs_q     <= '0;
         spc_q     <= '0;
         opc_q     <= '0;
         msk_q     <= '0;
         val_q     <= '0;
         wdat_q    <= '0;
         tmr_go_q  <= 1'b0;
         tmr_len_q <= '0;
         done      <= 1'b0;
         pass      <= 1'b0;
      end else begin
         done     <= 1'b0;
         tmr_go_q <= 1'b0;
         unique case (st_q)
            S_IDLE: begin
               if (start) begin
                  idx_q  <= '0;
                  pcnt_q <= '0;
                  st_q   <= S_FETCH;
               end
            end
            S_FETCH: st_q <= S_DECODE;
            S_DECODE: begin
               ofs_q <= cur.ofs;
               spc_q <= cur.space;
               opc_q <= cur.opc;
               msk_q <= cur.bmask;
               val_q <= cur.bval;
               if (!ent_hit) begin
                  st_q <= S_NEXT;
               end else begin
                  case (cur.opc)
                     OP_WRITE, OP_POLL: st_q <= S_RD;
                     OP_DELAY: begin
                        tmr_go_q  <= 1'b1;
                        tmr_len_q <= (cur.bval == DAT_W'(US_CODE)) ? CNT_W'(cur.ofs)
                                     : CNT_W'(cur.ofs) * CNT_W'(1000);
                        st_q      <= S_DLY;
                     end
                     OP_END: begin
                        done <= 1'b1;
                        pass <= 1'b1;
                        st_q <= S_IDLE;
                     end
                     default: st_q <= S_NEXT;
                  endcase
               end
            end
            S_RD: begin
               if (bus_ack) begin
                  if (opc_q == OP_WRITE) begin
                     wdat_q <= merged;
                     st_q   <= S_WR;
                  end else begin
                     pcnt_q <= pcnt_q + 1'b1;
                     if (pcnt_q > PCNT_W'(POLL_LIMIT)) begin
                        done <= 1'b1;
                        pass <= 1'b0;
                        st_q <= S_IDLE;
                     end else if (poll_match) begin
                        st_q <= S_NEXT;
                     end else begin
                        tmr_go_q  <= 1'b1;
                        tmr_len_q <= CNT_W'(POLL_GAP_US);
                        st_q      <= S_GAP;
                     end
                  end
               end
            end
            S_WR:   if (bus_ack) st_q <= S_NEXT;
            S_GAP:  if (tmr_fin) st_q <= S_RD;
            S_DLY:  if (tmr_fin) st_q <= S_NEXT;
            S_NEXT: begin
               idx_q <= idx_q + 1'b1;
               st_q  <= S_FETCH;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pwr_seq_engine_chk.sv
module pwr_seq_engine_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [IDX_W-1:0] tbl_addr,
   input logic             bus_req,
   input logic             bus_we,
   input logic             bus_sel,
   input logic [15:0]      bus_addr,
   input logic [7:0]       bus_wdata,
   input logic             bus_ack
);
   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)
                             && $stable(bus_sel) && $stable(bus_wdata));
   // R10
   req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> busy);
   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   // R9
   start_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy |=> busy && (tbl_addr == '0));
   // R10
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind pwr_seq_engine pwr_seq_engine_chk #(.IDX_W(IDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .tbl_addr  (tbl_addr),
   .bus_req   (bus_req),
   .bus_we    (bus_we),
   .bus_sel   (bus_sel),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_ack   (bus_ack)
);

// File: tb/pwr_seq_engine_tb_top.sv
module pwr_seq_engine_tb_top;
   import pwrseq_pkg::*;

   localparam int IDX_W = 4;
   localparam int CLKM  = 4;
   localparam int LIM   = 20;
   localparam int GAP   = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [7:0] cut_ver = 8'h02;
   logic [3:0] fab_ver = 4'h1;
   logic [3:0] intf_ver = 4'h4;
   logic busy, done, pass;
   logic [IDX_W-1:0] tbl_addr;
   logic [ENTRY_W-1:0] tbl_data;
   logic bus_req, bus_we, bus_sel, bus_ack;
   logic [15:0] bus_addr;
   logic [7:0] bus_wdata, bus_rdata;

   always #2.5 clk = ~clk;

   pwr_seq_engine #(.IDX_W(IDX_W), .CLK_MHZ(CLKM), .POLL_LIMIT(LIM), .POLL_GAP_US(GAP)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .cut_ver(cut_ver), .fab_ver(fab_ver),
      .intf_ver(intf_ver), .busy(busy), .done(done), .pass(pass), .tbl_addr(tbl_addr),
      .tbl_data(tbl_data), .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata));

   // table model (R12: one cycle latency)
   logic [ENTRY_W-1:0] rom [16];
   always @(posedge clk) tbl_data <= rom[tbl_addr];

   // register target model
   logic [7:0] mem_s [256];
   logic [7:0] mem_l [256];
   logic       mdl_clr = 1'b0;
   logic       pk_we = 1'b0, pk_sel = 1'b0;
   logic [7:0] pk_addr = '0, pk_data = '0;
   int m40 = 1000, m41 = 1000;
   int rd_cnt, wr_cnt, p40, p41, done_cnt, stab_err, min_gap, last_rd, cyc;
   int wcnt, lat;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (pk_we) begin
         if (pk_sel) mem_l[pk_addr] <= pk_data;
         else        mem_s[pk_addr] <= pk_data;
      end
      if (done) done_cnt <= done_cnt + 1;
      if (mdl_clr) begin
         rd_cnt <= 0; wr_cnt <= 0; p40 <= 0; p41 <= 0; done_cnt <= 0;
         min_gap <= 1000000; last_rd <= -1;
      end
      bus_rdata <= 8'h5A;
      if (!rst_n) begin
         bus_ack <= 1'b0; wcnt <= 0; lat <= 0;
      end else if (bus_ack) begin
         bus_ack <= 1'b0;
      end else if (bus_req) begin
         if (wcnt >= lat) begin
            bus_ack <= 1'b1;
            wcnt <= 0;
            lat <= (lat == 2) ? 0 : lat + 1;
            if (bus_we) begin
               wr_cnt <= wr_cnt + 1;
               if (bus_sel) mem_l[bus_addr[7:0]] <= bus_wdata;
               else         mem_s[bus_addr[7:0]] <= bus_wdata;
            end else begin
               rd_cnt <= rd_cnt + 1;
               if (!bus_sel && bus_addr == 16'h0040) begin
                  p40 <= p40 + 1;
                  bus_rdata <= {7'h78, (p40 + 1 >= m40)};
               end else if (!bus_sel && bus_addr == 16'h0041) begin
                  p41 <= p41 + 1;
                  bus_rdata <= {7'h78, (p41 + 1 >= m41)};
               end else begin
                  bus_rdata <= bus_sel ? mem_l[bus_addr[7:0]] : mem_s[bus_addr[7:0]];
               end
               if (last_rd >= 0 && cyc - last_rd < min_gap) min_gap <= cyc - last_rd;
               last_rd <= cyc;
            end
         end else begin
            wcnt <= wcnt + 1;
         end
      end
   end

   // R11 stability monitor
   logic p_req, p_ack, p_we, p_sel;
   logic [15:0] p_addr;
   logic [7:0] p_wd;
   initial stab_err = 0;
   always @(negedge clk) begin
      if (rst_n && p_req && !p_ack &&
          !(bus_req && bus_we == p_we && bus_sel == p_sel && bus_addr == p_addr && bus_wdata == p_wd))
         stab_err <= stab_err + 1;
      p_req <= bus_req; p_ack <= bus_ack; p_we <= bus_we; p_sel <= bus_sel;
      p_addr <= bus_addr; p_wd <= bus_wdata;
   end

   int errs = 0, checks = 0;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s: got %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errs++;
         $display("FAIL %s: got %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   function automatic logic [ENTRY_W-1:0] mk(input logic [15:0] ofs, input logic [7:0] cm,
      input logic [3:0] fm, input logic [3:0] im, input logic [3:0] sp,
      input logic [3:0] op, input logic [7:0] m, input logic [7:0] v);
      return {ofs, cm, fm, im, sp, op, m, v};
   endfunction

   function automatic logic [ENTRY_W-1:0] mka(input logic [15:0] ofs, input logic [3:0] sp,
      input logic [3:0] op, input logic [7:0] m, input logic [7:0] v);
      return mk(ofs, 8'hFF, 4'hF, 4'hF, sp, op, m, v);
   endfunction

   task automatic rom_clear();
      for (int i = 0; i < 16; i++) rom[i] = mka(16'h0, 4'h0, 4'd4, 8'h0, 8'h0);
   endtask

   task automatic poke(input logic s, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      pk_we = 1'b1; pk_sel = s; pk_addr = a; pk_data = d;
      @(negedge clk);
      pk_we = 1'b0;
   endtask

   int elapsed;
   task automatic run_seq();
      @(negedge clk);
      mdl_clr = 1'b1;
      @(negedge clk);
      mdl_clr = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      elapsed = 1;
      while (!done && elapsed < 20000) begin
         @(negedge clk);
         elapsed++;
      end
      if (!done) chk("watchdog run", 0, 1);
   endtask

   task automatic finish_up();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // {space code, initial byte, mask, value, expected byte}
   localparam logic [39:0] VEC [6] = '{
      40'h00_A5_0F_3C_AC,
      40'h01_00_FF_5A_5A,
      40'h00_FF_81_00_7E,
      40'h01_12_00_FF_12,
      40'h00_3C_F0_C3_CC,
      40'h02_55_AA_FF_FF
   };

   initial begin
      wait (cyc >= 190000);
      errs++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
   end

   initial begin
      rom_clear();
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 busy after reset", busy, 0);
      chk("R10 done after reset", done, 0);
      chk("R10 req after reset", bus_req, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 index after reset", tbl_addr, 0);

      // R2 / R3 vector walk
      foreach (VEC[i]) begin
         logic lsp;
         lsp = (VEC[i][39:32] == 8'h01);
         poke(lsp, 8'h10 + 8'(i), VEC[i][31:24]);
         poke(!lsp, 8'h10 + 8'(i), 8'hEE);
         rom_clear();
         rom[0] = mka(16'h0010 + 16'(i), VEC[i][35:32], 4'd1, VEC[i][23:16], VEC[i][15:8]);
         run_seq();
         chk("R7 pass after write", pass, 1);
         chk("R2 merged byte", lsp ? mem_l[8'h10 + 8'(i)] : mem_s[8'h10 + 8'(i)], VEC[i][7:0]);
         chk("R3 other space untouched", lsp ? mem_s[8'h10 + 8'(i)] : mem_l[8'h10 + 8'(i)], 8'hEE);
         chk("R2 one read one write", rd_cnt * 16 + wr_cnt, 16 + 1);
      end

      // R1 filter
      rom_clear();
      rom[0] = mk(16'h0020, 8'h01, 4'hF, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h11);
      rom[1] = mk(16'h0020, 8'hFF, 4'h2, 4'hF, 4'h0, 4'd1, 8'hFF, 8'h22);
      rom[2] = mk(16'h0020, 8'hFF, 4'hF, 4'h3, 4'h0, 4'd1, 8'hFF, 8'h33);
      rom[3] = mk(16'h0020, 8'h02, 4'h1, 4'h4, 4'h0, 4'd1, 8'hFF, 8'h44);
      run_seq();
      chk("R1 only matching entry writes", wr_cnt, 1);
      chk("R1 written value", mem_s[8'h20], 8'h44);
      chk("R1 pass", pass, 1);

      // R8 read and unknown opcodes
      rom_clear();
      rom[0] = mka(16'h0030, 4'h0, 4'd0, 8'hFF, 8'h01);
      rom[1] = mka(16'h0030, 4'h0, 4'd7, 8'hFF, 8'h02);
      rom[2] = mka(16'h0030, 4'h0, 4'd15, 8'hFF, 8'h03);
      rom[3] = mka(16'h0031, 4'h0, 4'd1, 8'hFF, 8'h66);
      run_seq();
      chk("R8 no reads from skipped opcodes", rd_cnt, 1);
      chk("R8 advance to write", mem_s[8'h31], 8'h66);

      // R7 end stops the run
      rom_clear();
      rom[1] = mka(16'h0032, 4'h0, 4'd1, 8'hFF, 8'h99);
      run_seq();
      chk("R7 pass", pass, 1);
      chk("R7 nothing after end", wr_cnt + rd_cnt, 0);

      // R6 delay microseconds / milliseconds
      rom_clear();
      rom[0] = mka(16'd5, 4'h0, 4'd3, 8'h00, 8'h00);
      run_seq();
      chk_rng("R6 us delay cycles", elapsed, 5 * CLKM, 5 * CLKM + 14);
      rom[0] = mka(16'd2, 4'h0, 4'd3, 8'h00, 8'h03);
      run_seq();
      chk_rng("R6 ms delay cycles", elapsed, 2000 * CLKM, 2000 * CLKM + 14);

      // R4 poll with gap
      rom_clear();
      m40 = 3;
      rom[0] = mka(16'h0040, 4'h0, 4'd2, 8'h01, 8'h01);
      run_seq();
      chk("R4 poll reads", p40, 3);
      chk("R4 poll pass", pass, 1);
      chk_rng("R4 poll gap", min_gap, GAP * CLKM, 100000);

      // R5 shared budget
      rom_clear();
      m40 = 15; m41 = 1000;
      rom[0] = mka(16'h0040, 4'h0, 4'd2, 8'h01, 8'h01);
      rom[1] = mka(16'h0041, 4'h0, 4'd2, 8'h01, 8'h01);
      run_seq();
      chk("R5 first poll reads", p40, 15);
      chk("R5 second poll reads", p41, LIM + 2 - 15);
      chk("R5 fail flag", pass, 0);
      // R9 counter cleared by new start
      m41 = 3;
      run_seq();
      chk("R9 budget cleared at start", pass, 1);
      chk("R9 total reads", p40 + p41, 18);

      // R9 start while busy ignored
      rom_clear();
      rom[0] = mka(16'd10, 4'h0, 4'd3, 8'h00, 8'h00);
      rom[1] = mka(16'h0050, 4'h0, 4'd1, 8'hFF, 8'h77);
      @(negedge clk);
      mdl_clr = 1'b1;
      @(negedge clk);
      mdl_clr = 1'b0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (200) @(negedge clk);
      chk("R9 single write", wr_cnt, 1);
      chk("R9 single done", done_cnt, 1);
      chk("R10 idle after run", busy, 0);

      // R11 handshake stability over the whole run
      chk("R11 stable during request", stab_err, 0);
      finish_up();
   end
endmodule